// File: doc/BRIEF.md
# Dual Time-Match Alarm Comparator

This block keeps two independent alarm register sets. Each set holds compare values for the second, minute, hour, date, month and day of week. Each of those fields carries its own enable in bit 7 of its byte. On every one-second tick, which the calendar logic raises after it has advanced the time, each alarm compares its enabled fields with the live BCD calendar values. If all enabled fields agree, that alarm's sticky status flag is set.

Enabling hour and minute alone gives an alarm that repeats every day. Adding the day-of-week field makes it repeat every week. An alarm with no enabled field never fires. A flag remains set until software clears it by writing a 1 to its bit. An interrupt line is driven high whenever a flag is set and that alarm's interrupt enable is also set. Software reaches all registers through a simple write port and a combinational read port.

Top module: `alarm_match_top`

## Requirements
- R1: A write stores into alarm n, field f at address 8n+f, with f = 0 second, 1 minute, 2 hour, 3 date, 4 month, 5 day of week. Bit 7 is the field enable. The value bits are 6:0 for second and minute, 5:0 for hour and date, 4:0 for month and 2:0 for day of week. Other bits read back as 0, so writing FFh reads back FFh, FFh, BFh, BFh, 9Fh or 87h for fields 0 to 5.
- R2: After reset, every alarm register, both status flags, the interrupt enables and irq are 0.
- R3: On a clock edge where tick is high, an alarm whose enabled fields all equal the calendar inputs sets its flag. The flag is visible on alarm_flag[n] right after that edge.
- R4: A field whose enable bit is 0 takes no part in the compare. Hour and minute alone match on any date, month, weekday and second.
- R5: An alarm with all six enable bits at 0 never sets its flag, even when its stored values equal the time.
- R6: Without tick, no flag is set, whatever the calendar inputs are.
- R7: The status register at address 6 reads the flags in bits 1:0. A flag stays set until a write to address 6 with a 1 in its bit. Writing 0 to a bit leaves that flag unchanged.
- R8: If a set and a clear of the same flag happen on the same edge, the set wins.
- R9: The register at address 7 holds the interrupt enables in bits 1:0. irq is high exactly when some flag is set with its enable bit set.
- R10: The two alarms are independent. Address 8n+f reaches only alarm n, and a match of one alarm never sets the other's flag.
- R11: The hour compare includes bit 5, the PM indicator in 12-hour format. 08h (AM) does not match a stored 28h (PM).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-second strobe, raised after the calendar update |
| cal_sec | input | 7 | Current seconds, BCD |
| cal_min | input | 7 | Current minutes, BCD |
| cal_hour | input | 6 | Current hour, BCD, bit 5 PM in 12-hour format |
| cal_date | input | 6 | Current date, BCD |
| cal_month | input | 5 | Current month, BCD |
| cal_wday | input | 3 | Current day of week, 0 to 6 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 8 | Read data, combinational |
| alarm_flag | output | 2 | Sticky alarm flags |
| irq | output | 1 | Interrupt request |

## Verification
The bench checks these corner cases, and what a faulty design would do in each:

- **No enabled field.** A stored value equal to the time with no enable bit set must not fire. A design that treats an empty enable set as "everything matched" would raise a spurious alarm every second.
- **Disabled fields.** Daily and weekly patterns are run against times that differ only in disabled fields. A design that compared every field would never fire them.
- **PM bit.** An AM/PM pair that differs only in bit 5 must not match. A design that masked the PM bit would fire twelve hours early.
- **Set against clear.** A tick and a clear are driven on the same edge, and a write of 0 is made to the status register. A design with the wrong priority, or one that clears on any write, would lose an alarm that software never saw.

// File: rtl/alarm_pkg.sv
package alarm_pkg;

  localparam int FIELD_CNT = 6;
  localparam int FIELD_IDX_W = 3;

  typedef struct packed {
    logic [6:0] sec;
    logic [6:0] min;
    logic [5:0] hour;
    logic [5:0] date;
    logic [4:0] month;
    logic [2:0] wday;
  } cal_t;

  // Bits kept in storage for field f: enable plus the value bits.
  function automatic logic [7:0] keep_mask(input int f);
    case (f)
      0, 1:    return 8'hFF;
      2, 3:    return 8'hBF;
      4:       return 8'h9F;
      default: return 8'h87;
    endcase
  endfunction

  // Live calendar value for field f, zero-extended to 7 bits.
  function automatic logic [6:0] cal_field(input cal_t c, input int f);
    case (f)
      0:       return c.sec;
      1:       return c.min;
      2:       return 7'(c.hour);
      3:       return 7'(c.date);
      4:       return 7'(c.month);
      default: return 7'(c.wday);
    endcase
  endfunction

endpackage

// File: rtl/alarm_set.sv
module alarm_set
  import alarm_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [FIELD_IDX_W-1:0] wr_field,
  input  logic [7:0]             wr_data,
  input  logic [FIELD_IDX_W-1:0] rd_field,
  input  cal_t                   cal,
  output logic [7:0]             rd_data,
  output logic                   hit
);

  logic [7:0] regs [FIELD_CNT];
  logic       any_en;
  logic       all_eq;

  for (genvar f = 0; f < FIELD_CNT; f++) begin : g_field
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[f] <= 8'h00;
      else if (wr_en && wr_field == FIELD_IDX_W'(f))
        regs[f] <= wr_data & keep_mask(f);
    end
  end

  always_comb begin
    rd_data = 8'h00;
    for (int f = 0; f < FIELD_CNT; f++)
      if (rd_field == FIELD_IDX_W'(f)) rd_data = regs[f];
  end

  always_comb begin
    any_en = 1'b0;
    all_eq = 1'b1;
    for (int f = 0; f < FIELD_CNT; f++) begin
      if (regs[f][7]) begin
        any_en = 1'b1;
        if (regs[f][6:0] != cal_field(cal, f)) all_eq = 1'b0;
      end
    end
  end

  assign hit = any_en && all_eq;

  // R5
  no_enable_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(regs[0][7] | regs[1][7] | regs[2][7] | regs[3][7] | regs[4][7] | regs[5][7]) |-> !hit);

  // R4
  disabled_second_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!regs[0][7] && $stable(regs[1]) && $stable(regs[2]) && $stable(regs[3]) &&
     $stable(regs[4]) && $stable(regs[5]) && regs[0] == $past(regs[0]) &&
     $stable(cal.min) && $stable(cal.hour) && $stable(cal.date) &&
     $stable(cal.month) && $stable(cal.wday)) |-> hit == $past(hit));

endmodule

// File: rtl/alarm_flags.sv
module alarm_flags #(
  parameter int NUM_ALARMS = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic [NUM_ALARMS-1:0] hit,
  input  logic                  clr_en,
  input  logic [NUM_ALARMS-1:0] clr_mask,
  input  logic                  ien_wr,
  input  logic [NUM_ALARMS-1:0] ien_data,
  output logic [NUM_ALARMS-1:0] flags,
  output logic [NUM_ALARMS-1:0] ien,
  output logic                  irq
);

  logic [NUM_ALARMS-1:0] set_vec;
  logic [NUM_ALARMS-1:0] clr_vec;

  assign set_vec = tick ? hit : '0;
  assign clr_vec = clr_en ? clr_mask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      ien   <= '0;
    end else begin
      flags <= (flags & ~clr_vec) | set_vec;
      if (ien_wr) ien <= ien_data;
    end
  end

  assign irq = |(flags & ien);

  for (genvar i = 0; i < NUM_ALARMS; i++) begin : g_chk
    // R3
    set_on_tick_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && hit[i]) |=> flags[i]);
    // R6
    no_set_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[i]) |-> $past(tick && hit[i]));
    // R7
    sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[i] && !(clr_en && clr_mask[i])) |=> flags[i]);
  end

endmodule

// File: rtl/alarm_match_top.sv
module alarm_match_top
  import alarm_pkg::*;
#(
  parameter int NUM_ALARMS = 2,
  localparam int SEL_W     = (NUM_ALARMS > 1) ? $clog2(NUM_ALARMS) : 1,
  localparam int ADDR_W    = SEL_W + FIELD_IDX_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic [6:0]            cal_sec,
  input  logic [6:0]            cal_min,
  input  logic [5:0]            cal_hour,
  input  logic [5:0]            cal_date,
  input  logic [4:0]            cal_month,
  input  logic [2:0]            cal_wday,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [7:0]            wr_data,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [7:0]            rd_data,
  output logic [NUM_ALARMS-1:0] alarm_flag,
  output logic                  irq
);

  localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] IEN_ADDR    = ADDR_W'(7);

  cal_t                  cal;
  logic [NUM_ALARMS-1:0] hit;
  logic [7:0]            set_rd [NUM_ALARMS];
  logic [NUM_ALARMS-1:0] ien;

  assign cal = '{sec: cal_sec, min: cal_min, hour: cal_hour,
                 date: cal_date, month: cal_month, wday: cal_wday};

  for (genvar n = 0; n < NUM_ALARMS; n++) begin : g_alarm
    alarm_set u_set (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en && wr_addr[ADDR_W-1:FIELD_IDX_W] == SEL_W'(n)),
      .wr_field (wr_addr[FIELD_IDX_W-1:0]),
      .wr_data  (wr_data),
      .rd_field (rd_addr[FIELD_IDX_W-1:0]),
      .cal      (cal),
      .rd_data  (set_rd[n]),
      .hit      (hit[n])
    );
  end

  alarm_flags #(.NUM_ALARMS(NUM_ALARMS)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .hit      (hit),
    .clr_en   (wr_en && wr_addr == STATUS_ADDR),
    .clr_mask (wr_data[NUM_ALARMS-1:0]),
    .ien_wr   (wr_en && wr_addr == IEN_ADDR),
    .ien_data (wr_data[NUM_ALARMS-1:0]),
    .flags    (alarm_flag),
    .ien      (ien),
    .irq      (irq)
  );

  always_comb begin
    rd_data = 8'h00;
    if (rd_addr == STATUS_ADDR)
      rd_data = 8'(alarm_flag);
    else if (rd_addr == IEN_ADDR)
      rd_data = 8'(ien);
    else
      for (int n = 0; n < NUM_ALARMS; n++)
        if (rd_addr[ADDR_W-1:FIELD_IDX_W] == SEL_W'(n)) rd_data = set_rd[n];
  end

  // R9
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (alarm_flag != '0));

endmodule

// File: tb/tb_alarm_match_top.sv
module tb_alarm_match_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [6:0] cal_sec = '0, cal_min = '0;
  logic [5:0] cal_hour = '0, cal_date = '0;
  logic [4:0] cal_month = '0;
  logic [2:0] cal_wday = '0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [1:0] alarm_flag;
  logic       irq;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  alarm_match_top dut (.*);

  // {cfg sec,min,hour,date,month,wday ; time sec,min,hour,date,month,wday ; expected}
  localparam int NV = 10;
  localparam logic [96:0] VEC [NV] = '{
    {8'hC5,8'hB0,8'h92,8'h95,8'h86,8'h83, 8'h45,8'h30,8'h12,8'h15,8'h06,8'h03, 1'b1}, // R3 all fields
    {8'hC5,8'hB0,8'h92,8'h95,8'h86,8'h83, 8'h46,8'h30,8'h12,8'h15,8'h06,8'h03, 1'b0}, // R3 second off
    {8'h00,8'hB0,8'h92,8'h00,8'h00,8'h00, 8'h07,8'h30,8'h12,8'h28,8'h11,8'h05, 1'b1}, // R4 daily
    {8'h00,8'hB0,8'h92,8'h00,8'h00,8'h00, 8'h07,8'h31,8'h12,8'h28,8'h11,8'h05, 1'b0}, // R4 daily miss
    {8'h00,8'hB0,8'h92,8'h00,8'h00,8'h83, 8'h00,8'h30,8'h12,8'h01,8'h01,8'h03, 1'b1}, // R4 weekly
    {8'h00,8'hB0,8'h92,8'h00,8'h00,8'h83, 8'h00,8'h30,8'h12,8'h01,8'h01,8'h04, 1'b0}, // R4 weekly miss
    {8'h45,8'h30,8'h12,8'h15,8'h06,8'h03, 8'h45,8'h30,8'h12,8'h15,8'h06,8'h03, 1'b0}, // R5 none enabled
    {8'h00,8'h00,8'hA8,8'h00,8'h00,8'h00, 8'h00,8'h00,8'h08,8'h00,8'h00,8'h00, 1'b0}, // R11 AM vs PM
    {8'h00,8'h00,8'hA8,8'h00,8'h00,8'h00, 8'h00,8'h00,8'h28,8'h00,8'h00,8'h00, 1'b1}, // R11 PM
    {8'h00,8'h00,8'h00,8'h00,8'h92,8'h00, 8'h59,8'h59,8'h23,8'h31,8'h12,8'h06, 1'b1}  // R4 month only
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] s, mi, h, dt, mo, wd);
    cal_sec = s[6:0]; cal_min = mi[6:0]; cal_hour = h[5:0];
    cal_date = dt[5:0]; cal_month = mo[4:0]; cal_wday = wd[2:0];
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // R2 reset state
    chk("R2 flags", 8'(alarm_flag), 8'h00);
    chk("R2 irq", 8'(irq), 8'h00);
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), d);
      chk("R2 register", d, 8'h00);
    end

    // Vector walk on alarm 0, alarm 1 left all disabled
    for (int v = 0; v < NV; v++) begin
      for (int f = 0; f < 6; f++) wr(4'(f), VEC[v][96-8*f -: 8]);
      wr(4'd6, 8'h03);
      set_time(VEC[v][48:41], VEC[v][40:33], VEC[v][32:25],
               VEC[v][24:17], VEC[v][16:9], VEC[v][8:1]);
      pulse_tick();
      chk("R3/R4/R5/R11 alarm0 flag", 8'(alarm_flag[0]), 8'(VEC[v][0]));
      chk("R10 alarm1 untouched", 8'(alarm_flag[1]), 8'h00);
    end

    // R1 write masks
    do_reset();
    wr(4'd0, 8'hFF); wr(4'd2, 8'hFF); wr(4'd3, 8'hFF);
    wr(4'd4, 8'hFF); wr(4'd5, 8'hFF);
    rd(4'd0, d); chk("R1 sec", d, 8'hFF);
    rd(4'd2, d); chk("R1 hour", d, 8'hBF);
    rd(4'd3, d); chk("R1 date", d, 8'hBF);
    rd(4'd4, d); chk("R1 month", d, 8'h9F);
    rd(4'd5, d); chk("R1 wday", d, 8'h87);
    rd(4'd10, d); chk("R1 R10 alarm1 hour not written", d, 8'h00);

    // R6 no tick, no flag
    do_reset();
    wr(4'd0, 8'h80);
    set_time(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    repeat (5) @(negedge clk);
    chk("R6 no tick", 8'(alarm_flag), 8'h00);

    // R9 irq gated by enable; R7 sticky and clear
    pulse_tick();
    chk("R3 flag set", 8'(alarm_flag), 8'h01);
    chk("R9 irq masked", 8'(irq), 8'h00);
    wr(4'd7, 8'h01);
    chk("R9 irq enabled", 8'(irq), 8'h01);
    rd(4'd7, d); chk("R9 enable readback", d, 8'h01);
    set_time(8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    repeat (4) @(negedge clk);
    chk("R7 still set", 8'(alarm_flag), 8'h01);
    wr(4'd6, 8'h00);
    chk("R7 write zero keeps", 8'(alarm_flag), 8'h01);
    rd(4'd6, d); chk("R7 status read", d, 8'h01);
    wr(4'd6, 8'h01);
    chk("R7 cleared", 8'(alarm_flag), 8'h00);
    chk("R9 irq dropped", 8'(irq), 8'h00);

    // R8 set beats clear
    set_time(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; wr_addr = 4'd6; wr_data = 8'h01;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    chk("R8 set wins", 8'(alarm_flag), 8'h01);

    // R10 independence
    do_reset();
    wr(4'd1, 8'hA0);
    wr(4'd9, 8'h95);
    set_time(8'h00, 8'h15, 8'h00, 8'h00, 8'h00, 8'h00);
    pulse_tick();
    chk("R10 only alarm1", 8'(alarm_flag), 8'h02);
    rd(4'd6, d); chk("R10 status", d, 8'h02);
    wr(4'd7, 8'h01);
    chk("R9 R10 irq other enable", 8'(irq), 8'h00);
    wr(4'd7, 8'h02);
    chk("R9 irq alarm1", 8'(irq), 8'h01);

    summary();
    $finish;
  end

endmodule